// File: doc/BRIEF.md
# Multi-Rate TDM Time-Slot Switch

This block exchanges 8-bit time slots between serial TDM streams. The input streams and the output streams each run at 2.048, 4.096 or 8.192 Mb/s, and the two rates may differ. With different rates the block merges several slow streams onto fewer fast ones, or spreads fast streams across more slow ones. Every rate setting gives 256 input channels and 256 output channels. Any output channel can take any input channel, so the switch never blocks.

A single clock paces the block at one cycle per 8.192 Mb/s bit time, and an active-low frame pulse marks the 125 us frame boundary. A write port loads two things: a mode word, and a table that holds one entry for each output channel. Each table entry names the source channel. It also chooses between a fixed one-frame delay and the lowest delay that is available. Input bytes go into a data store with one buffer per frame, and the output serialisers read from that store.

Top module: `tdm_rate_switch`

## Requirements
- R1: The cycle after `frameN` is sampled low is tick 0 of a new frame, and a frame lasts 1024 ticks. One bit lasts 4 ticks at 2.048 Mb/s, 2 ticks at 4.096 Mb/s and 1 tick at 8.192 Mb/s.
- R2: Rate codes are 0 = 2.048, 1 = 4.096 and 2 = 8.192 Mb/s, and code 3 behaves as code 0. Mode word bit 0 set selects split rates: the input rate comes from bits [4:3], the output rate from bits [6:5], and bits [2:1] are ignored. With bit 0 clear, bits [2:1] set both rates, and bits [6:3] are ignored.
- R3: A rate of 2.048, 4.096 or 8.192 Mb/s uses 8, 4 or 2 streams carrying 32, 64 or 128 channels each. Channel c of stream s has flat index (s << (5+rate)) | c.
- R4: Input bits are taken MSB first, on the last tick of each bit period. Streams beyond the active input count are ignored.
- R5: Output bits are sent MSB first, one tick after the frame timing of their bit. The enable does not change inside a channel slot.
- R6: A write with `wrSel`=0 loads the mode word. A write with `wrSel`=1 loads the table entry at output flat index `wrAddr`, with fields [6:0] source channel, [9:7] source stream, [10] constant delay and [11] enable. Neither kind of write takes effect before the next frame boundary.
- R7: A constant-delay channel outputs the source byte received in the previous frame.
- R8: A variable-delay channel outputs the current frame's byte when the source channel's last bit period ends no later than the first tick of the output channel. Otherwise it outputs the previous frame's byte.
- R9: An entry whose enable is clear, or whose source stream or channel is outside the active input range, drives enable 0 and data 0.
- R10: Output streams beyond the active output count drive enable 0 and data 0.
- R11: After reset the tick is 0, the mode word is 0, all table entries are disabled and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one cycle per 8.192 Mb/s bit |
| rstN | input | 1 | Asynchronous active-low reset |
| frameN | input | 1 | Active-low frame pulse, one cycle before tick 0 |
| sti | input | 8 | Serial input streams |
| wrEn | input | 1 | Write strobe |
| wrSel | input | 1 | 0 selects the mode word, 1 selects the connection table |
| wrAddr | input | 8 | Output flat index for table writes |
| wrData | input | 12 | Mode word in [6:0], or a table entry |
| sto | output | 8 | Serial output streams |
| stoEn | output | 8 | Per-stream output drive enable |

## Verification
The assertions assume that `frameN` pulses only at the end of tick 1023 and that the mode word changes only at a frame boundary. Under those conditions the per-slot enable holds and the bank alternates once per frame. The bench drives the pulse from its own tick count, with exactly 1024 ticks between pulses. It writes the table and mode only in the middle of a frame. Data checks start only when the previous frame used the same input rate, so both frames' bytes share one index layout.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  localparam int MAX_STREAMS = 8;
  localparam int BASE_CHANS  = 32;
  localparam int CHAN_TOTAL  = MAX_STREAMS * BASE_CHANS;
  localparam int IDX_W       = $clog2(CHAN_TOTAL);
  localparam int FRAME_TICKS = 1024;
  localparam int TICK_W      = $clog2(FRAME_TICKS);
  localparam int CHAN_W      = TICK_W - 3;
  localparam int MODE_W      = 7;

  typedef logic [1:0] rate_t;

  typedef struct packed {
    logic [TICK_W-1:0] tick;
    logic              bank;
    logic              apply;
    rate_t             inRate;
    rate_t             outRate;
  } ctl_t;

  typedef struct packed {
    logic        enable;
    logic        constDelay;
    logic [2:0]  srcStream;
    logic [6:0]  srcChan;
  } conn_t;

  function automatic rate_t clampRate(input rate_t r);
    return (r == 2'd3) ? 2'd0 : r;
  endfunction

  function automatic logic [IDX_W-1:0] packIdx(input logic [2:0] s,
                                               input logic [CHAN_W-1:0] c,
                                               input rate_t r);
    logic [IDX_W-1:0] sw;
    sw = IDX_W'(s);
    return (sw << (3'd5 + 3'(r))) | IDX_W'(c);
  endfunction
endpackage

// File: rtl/tsw_ctrl.sv
module tsw_ctrl
  import tsw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameN,
  input  logic              modeWe,
  input  logic [MODE_W-1:0] modeData,
  output ctl_t              ctl
);
  logic [TICK_W-1:0] tick;
  logic              bank;
  logic [MODE_W-1:0] modeShadow;
  logic [MODE_W-1:0] modeAct;
  rate_t             sameRate;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tick       <= '0;
      bank       <= 1'b0;
      modeShadow <= '0;
      modeAct    <= '0;
    end else begin
      if (modeWe) modeShadow <= modeData;
      if (!frameN) begin
        tick    <= '0;
        bank    <= ~bank;
        modeAct <= modeShadow;
      end else begin
        tick <= tick + 1'b1;
      end
    end
  end

  always_comb begin
    sameRate    = clampRate(modeAct[2:1]);
    ctl.tick    = tick;
    ctl.bank    = bank;
    ctl.apply   = !frameN;
    ctl.inRate  = modeAct[0] ? clampRate(modeAct[4:3]) : sameRate;
    ctl.outRate = modeAct[0] ? clampRate(modeAct[6:5]) : sameRate;
  end

  assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(frameN) |-> $stable(modeAct));

  assert_bank_flip_R1: assert property (@(posedge clk) disable iff (!rstN)
    !frameN |=> (bank != $past(bank)));
endmodule

// File: rtl/tsw_datapath.sv
module tsw_datapath
  import tsw_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  ctl_t                   ctl,
  input  logic [MAX_STREAMS-1:0] sti,
  input  logic                   connWe,
  input  logic [IDX_W-1:0]       connAddr,
  input  conn_t                  connData,
  output logic [MAX_STREAMS-1:0] sto,
  output logic [MAX_STREAMS-1:0] stoEn
);
  logic [7:0] dataMem [2][CHAN_TOTAL];
  conn_t      connShadow [CHAN_TOTAL];
  conn_t      connAct [CHAN_TOTAL];
  logic [7:0] shReg [MAX_STREAMS];
  logic [7:0] holdByte [MAX_STREAMS];
  logic [MAX_STREAMS-1:0] holdValid;

  logic [1:0]        inShift, outShift;
  logic [TICK_W-1:0] inMask, slotMask, inBits, outBits;
  logic              inSample, slotStart;
  int                nIn, nOut, nChIn;

  conn_t             connSel [MAX_STREAMS];
  logic [IDX_W-1:0]  srcIdx [MAX_STREAMS];
  logic [TICK_W:0]   endTick [MAX_STREAMS];
  logic [7:0]        lookByte [MAX_STREAMS];
  logic [MAX_STREAMS-1:0] useCur, lookValid, curValid, curBit;

  // Rate-dependent slot timing
  always_comb begin
    inShift   = 2'd2 - ctl.inRate;
    outShift  = 2'd2 - ctl.outRate;
    inMask    = (TICK_W'(1) << inShift) - TICK_W'(1);
    slotMask  = (TICK_W'(8) << outShift) - TICK_W'(1);
    inSample  = (ctl.tick & inMask) == inMask;
    slotStart = (ctl.tick & slotMask) == '0;
    inBits    = ctl.tick >> inShift;
    outBits   = ctl.tick >> outShift;
    nIn       = MAX_STREAMS >> ctl.inRate;
    nOut      = MAX_STREAMS >> ctl.outRate;
    nChIn     = BASE_CHANS << ctl.inRate;
  end

  // Input deserialisers write completed bytes into this frame's bank
  always_ff @(posedge clk) begin
    if (inSample) begin
      for (int s = 0; s < MAX_STREAMS; s++) begin
        if (s < nIn) begin
          shReg[s] <= {shReg[s][6:0], sti[s]};
          if (inBits[2:0] == 3'd7)
            dataMem[ctl.bank][packIdx(3'(s), inBits[TICK_W-1:3], ctl.inRate)]
              <= {shReg[s][6:0], sti[s]};
        end
      end
    end
  end

  // Connection table: shadow copy applied at the frame boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < CHAN_TOTAL; i++) begin
        connShadow[i] <= '0;
        connAct[i]    <= '0;
      end
    end else begin
      if (connWe) connShadow[connAddr] <= connData;
      if (ctl.apply) connAct <= connShadow;
    end
  end

  // Per-output-stream source lookup
  always_comb begin
    for (int s = 0; s < MAX_STREAMS; s++) begin
      connSel[s]   = connAct[packIdx(3'(s), outBits[TICK_W-1:3], ctl.outRate)];
      lookValid[s] = connSel[s].enable && (int'(connSel[s].srcStream) < nIn)
                     && (int'(connSel[s].srcChan) < nChIn);
      srcIdx[s]    = packIdx(connSel[s].srcStream, connSel[s].srcChan, ctl.inRate);
      endTick[s]   = ((TICK_W+1)'(connSel[s].srcChan) + (TICK_W+1)'(1)) << (3 + int'(inShift));
      useCur[s]    = !connSel[s].constDelay && (endTick[s] <= {1'b0, ctl.tick});
      lookByte[s]  = dataMem[useCur[s] ? ctl.bank : !ctl.bank][srcIdx[s]];
      curValid[s]  = (s < nOut) && (slotStart ? lookValid[s] : holdValid[s]);
      curBit[s]    = slotStart ? lookByte[s][3'd7 - outBits[2:0]]
                               : holdByte[s][3'd7 - outBits[2:0]];
    end
  end

  // Output serialisers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sto       <= '0;
      stoEn     <= '0;
      holdValid <= '0;
      for (int s = 0; s < MAX_STREAMS; s++) holdByte[s] <= '0;
    end else begin
      sto   <= curValid & curBit;
      stoEn <= curValid;
      if (slotStart) begin
        holdValid <= lookValid;
        for (int s = 0; s < MAX_STREAMS; s++) holdByte[s] <= lookByte[s];
      end
    end
  end

  for (genvar g = 0; g < MAX_STREAMS; g++) begin : g_chk
    assert_quiet_disabled_R9: assert property (@(posedge clk) disable iff (!rstN)
      !stoEn[g] |-> !sto[g]);
    assert_idle_stream_R10: assert property (@(posedge clk) disable iff (!rstN)
      (g >= $past(nOut)) |-> !stoEn[g]);
    assert_enable_held_R5: assert property (@(posedge clk) disable iff (!rstN)
      $past(!slotStart) |-> $stable(stoEn[g]));
  end
endmodule

// File: rtl/tdm_rate_switch.sv
module tdm_rate_switch
  import tsw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameN,
  input  logic [7:0]  sti,
  input  logic        wrEn,
  input  logic        wrSel,
  input  logic [7:0]  wrAddr,
  input  logic [11:0] wrData,
  output logic [7:0]  sto,
  output logic [7:0]  stoEn
);
  ctl_t ctl;

  tsw_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .frameN   (frameN),
    .modeWe   (wrEn & ~wrSel),
    .modeData (wrData[MODE_W-1:0]),
    .ctl      (ctl)
  );

  tsw_datapath i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .sti      (sti),
    .connWe   (wrEn & wrSel),
    .connAddr (wrAddr),
    .connData (conn_t'(wrData)),
    .sto      (sto),
    .stoEn    (stoEn)
  );
endmodule

// File: tb/test_tdm_rate_switch.sv
`timescale 1ns/1ps
module test_tdm_rate_switch;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameN = 1'b1;
  logic [7:0]  sti = '0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [11:0] wrData = '0;
  logic [7:0]  sto, stoEn;

  int tests = 0;
  int failed = 0;
  bit done = 1'b0;
  int act [256];
  int shadow [256];
  int ri, ro, prevRi, modeSh, modeLive;
  int tp, bi, c, bp, tS, o, e, st, ch, srcIdx, b;
  bit valid, cur, dl;

  always #4 clk = ~clk;

  tdm_rate_switch i_tdm_rate_switch (
    .clk(clk), .rstN(rstN), .frameN(frameN), .sti(sti), .wrEn(wrEn),
    .wrSel(wrSel), .wrAddr(wrAddr), .wrData(wrData), .sto(sto), .stoEn(stoEn)
  );

  function automatic int rateOf(int code);
    return (code == 3) ? 0 : code;
  endfunction
  function automatic int inRateOf(int m);
    return (m & 1) ? rateOf((m >> 3) & 3) : rateOf((m >> 1) & 3);
  endfunction
  function automatic int outRateOf(int m);
    return (m & 1) ? rateOf((m >> 5) & 3) : rateOf((m >> 1) & 3);
  endfunction
  function automatic int genByte(int fr, int idx);
    return (idx ^ (fr * 91 + 17)) & 255;
  endfunction
  // Split-rate words set ignored bits [2:1]; same-rate words set ignored bits [6:3] (R2)
  function automatic int modeWord(int i);
    case (i)
      0: return 1 | (0 << 3) | (1 << 5) | (2 << 1);
      1: return 1 | (0 << 3) | (2 << 5) | (1 << 1);
      2: return 1 | (1 << 3) | (0 << 5) | (2 << 1);
      3: return 1 | (2 << 3) | (0 << 5) | (1 << 1);
      4: return (1 << 1) | (2 << 3);
      5: return (2 << 1) | (1 << 5);
      default: return (3 << 1) | (1 << 3) | (2 << 5);
    endcase
  endfunction
  function automatic int connWord(int i, int oi);
    int r, src, s, k;
    r   = inRateOf(modeWord(i));
    src = (oi * 73 + i * 29 + 5) & 255;
    s   = src >> (5 + r);
    k   = src & ((32 << r) - 1);
    if ((oi % 29) == 7 && (8 >> r) < 8) s = 8 >> r;
    if ((oi % 31) == 9 && r < 2) k = 32 << r;
    return (((oi % 13) != 3) << 11) | (((oi + i) & 1) << 10) | (s << 7) | k;
  endfunction

  task automatic check(string tag, int t, int s, logic gotD, logic gotE, logic expD, logic expE);
    tests++;
    if (gotD !== expD || gotE !== expE) begin
      failed++;
      $display("FAIL %s tick=%0d stream=%0d got sto=%0b en=%0b expected sto=%0b en=%0b",
               tag, t, s, gotD, gotE, expD, expE);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      tests++;
      failed++;
      $display("FAIL R1 watchdog expired got running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      act[i] = 0;
      shadow[i] = 0;
    end
    ri = 0; ro = 0; prevRi = 0; modeSh = 0; modeLive = 0;
    repeat (3) @(negedge clk);
    for (int s = 0; s < 8; s++) check("R11", 0, s, sto[s], stoEn[s], 1'b0, 1'b0);
    rstN = 1'b1;
    for (int f = 0; f < 29; f++) begin
      for (int t = 0; t < 1024; t++) begin
        if (t == 0 && f > 0) begin
          prevRi = ri;
          for (int i = 0; i < 256; i++) act[i] = shadow[i];
          modeLive = modeSh;
          ri = inRateOf(modeLive);
          ro = outRateOf(modeLive);
        end
        // outputs now show the bit timed at tick t-1
        if (t != 0) begin
          tp = t - 1;
          for (int s = 0; s < 8; s++) begin
            if (s >= (8 >> ro)) begin
              check("R10", tp, s, sto[s], stoEn[s], 1'b0, 1'b0);
            end else begin
              bi = tp >> (2 - ro);
              c  = bi >> 3;
              bp = bi & 7;
              tS = (c * 8) << (2 - ro);
              o  = (s << (5 + ro)) | c;
              e  = act[o];
              dl = ((e >> 10) & 1) != 0;
              st = (e >> 7) & 7;
              ch = e & 127;
              valid = ((e >> 11) & 1) != 0 && st < (8 >> ri) && ch < (32 << ri);
              if (!valid) begin
                check("R9", tp, s, sto[s], stoEn[s], 1'b0, 1'b0);
              end else if (f >= 1 && prevRi == ri) begin
                srcIdx = (st << (5 + ri)) | ch;
                cur = !dl && ((((ch + 1) * 8) << (2 - ri)) <= tS);
                b = genByte(cur ? f : f - 1, srcIdx);
                check(dl ? "R1 R2 R3 R4 R5 R6 R7" : "R1 R2 R3 R4 R5 R6 R8",
                      tp, s, sto[s], stoEn[s], 1'((b >> (7 - bp)) & 1), 1'b1);
              end
            end
          end
        end
        bi = t >> (2 - ri);
        c  = bi >> 3;
        bp = bi & 7;
        for (int s = 0; s < 8; s++)
          sti[s] = (s < (8 >> ri)) ? 1'((genByte(f, (s << (5 + ri)) | c) >> (7 - bp)) & 1) : 1'b0;
        wrEn = 1'b0;
        if ((f % 4) == 0 && (f / 4) < 7) begin
          if (t >= 8 && t < 264) begin
            wrEn   = 1'b1;
            wrSel  = 1'b1;
            wrAddr = 8'(t - 8);
            wrData = 12'(connWord(f / 4, t - 8));
            shadow[t - 8] = connWord(f / 4, t - 8);
          end else if (t == 300) begin
            wrEn   = 1'b1;
            wrSel  = 1'b0;
            wrAddr = '0;
            wrData = 12'(modeWord(f / 4));
            modeSh = modeWord(f / 4);
          end
        end
        frameN = (t == 1023) ? 1'b0 : 1'b1;
        @(negedge clk);
      end
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule